// File: doc/BRIEF.md
# Multi-Level Daisy-Chain Bus Arbiter

This block decides which of several devices may drive one shared bus. Each device raises its own request line. The requests run along daisy chains toward a central decision point. Device index 0 sits closest to that point, and index N_DEV-1 sits farthest from it. Inside one chain, the nearest requesting device blocks every device behind it, so the arbiter only has to grant the first requester it sees.

There are several independent chains, called levels. Every device has a small writable register that picks its level. Level 0 has the highest priority. A device on a lower-numbered level therefore overtakes nearer devices that sit on a higher-numbered level. Software can change a device's level, but not while that device holds the grant.

The controller has two states:
- `S_IDLE`: no grant is out.
  - Transition *award*: when at least one request is pending and `bus_busy` is low, the controller moves to `S_GRANT` with the chosen owner.
  - Otherwise it stays in `S_IDLE`.
- `S_GRANT`: exactly one grant is driven.
  - Transition *hold*: the controller stays in `S_GRANT` while the owner keeps its request high.
  - Transition *release*: when the owner drops its request, the controller returns to `S_IDLE`.

Top module: `daisy_arb`

## Requirements
- R1: After reset, no grant is asserted and every device sits on level N_LVL-1 (the lowest priority).
- R2: At most one bit of `gnt` is high in any cycle.
- R3: Among requesters on the same winning level, the lowest device index (nearest the arbiter) is granted.
- R4: A requester on a lower-numbered level wins over every requester on a higher-numbered level, whatever their positions.
- R5: Once granted, a device keeps the grant for as long as its request stays high. It keeps it even when a higher-priority request appears.
- R6: When the owner's request is low at a clock edge, the grant drops at that edge. The bus then stays ungranted for exactly one cycle before the next award, if a request is pending and `bus_busy` is low.
- R7: While no grant is out, `bus_busy` high prevents any award. It does not revoke a grant that is already held.
- R8: A grant is awarded on the edge that samples the request. It goes only to a device whose request was high at that edge.
- R9: A level write (`cfg_we`, `cfg_dev`, `cfg_lvl`) to the device currently granted is ignored. A write to any other device takes effect for arbitrations at later edges. An arbitration on the same edge as the write uses the old level.
- R10: A level write whose value is N_LVL or above is ignored, and the device keeps its previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_DEV | Per-device bus request; bit 0 is nearest the arbiter |
| bus_busy | input | 1 | High while the bus is still occupied; blocks new awards |
| cfg_we | input | 1 | Level register write strobe |
| cfg_dev | input | $clog2(N_DEV) | Device index addressed by the write |
| cfg_lvl | input | $clog2(N_LVL) | Level value to write; 0 is highest priority |
| gnt | output | N_DEV | One-hot grant, all zero when the bus is free |

## Verification
A level write can land on the same edge as a release or an award. In that case the arbitration must still use the old levels, and the lock must follow the owner that is current at that edge. A random phase provokes this: it mixes level writes to random devices, including the current owner, with request drops and `bus_busy` pulses, so writes often fall on release and award cycles. A behavioural model in the bench applies the write only after it has resolved the arbitration, and it compares the grant vector on every cycle. Directed sequences also cover a write to the owner just before it releases and a write to a waiting device just before an award.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_GRANT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/daisy_arb_chain.sv
// One request chain: position 0 is nearest the arbiter and blocks all behind it.
module daisy_arb_chain #(
    parameter int N_DEV = 8
) (
    input  logic [N_DEV-1:0] lane_req,
    output logic [N_DEV-1:0] lane_win,
    output logic             lane_any
);
    logic [N_DEV:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N_DEV; i++) begin : g_link
        assign lane_win[i]    = lane_req[i] & ~blocked[i];
        assign blocked[i + 1] = blocked[i] | lane_req[i];
    end

    assign lane_any = blocked[N_DEV];
endmodule

// File: rtl/daisy_arb_lvlreg.sv
// Per-device chain-level registers with a write lock for the current holder.
module daisy_arb_lvlreg #(
    parameter int N_DEV = 8,
    parameter int N_LVL = 3,
    localparam int DW = $clog2(N_DEV),
    localparam int LW = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_dev,
    input  logic [LW-1:0]     wr_lvl,
    input  logic [N_DEV-1:0]  held,
    output logic [N_DEV*LW-1:0] lvl_flat
);
    localparam logic [LW-1:0] LVL_RESET = LW'(N_LVL - 1);

    logic in_range;
    assign in_range = ({1'b0, wr_lvl} < (LW + 1)'(N_LVL));

    for (genvar d = 0; d < N_DEV; d++) begin : g_reg
        logic [LW-1:0] lvl_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q <= LVL_RESET;
            end else if (wr_en && in_range && !held[d] && (wr_dev == DW'(d))) begin
                lvl_q <= wr_lvl;
            end
        end

        assign lvl_flat[d*LW +: LW] = lvl_q;
    end

    // R9: a write aimed at the holder leaves every level untouched
    p_cfg_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && held[wr_dev]) |=> $stable(lvl_flat));

    // R10: an out-of-range level value is dropped
    p_cfg_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_lvl} >= (LW + 1)'(N_LVL))) |=> $stable(lvl_flat));
endmodule

// File: rtl/daisy_arb.sv
module daisy_arb
    import daisy_arb_pkg::*;
#(
    parameter int N_DEV = 8,
    parameter int N_LVL = 3,
    localparam int DW = $clog2(N_DEV),
    localparam int LW = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] req,
    input  logic             bus_busy,
    input  logic             cfg_we,
    input  logic [DW-1:0]    cfg_dev,
    input  logic [LW-1:0]    cfg_lvl,
    output logic [N_DEV-1:0] gnt
);
    arb_state_e state_q, state_d;
    logic [DW-1:0] owner_q, owner_d;

    logic [N_DEV*LW-1:0]            lvl_flat;
    logic [N_LVL-1:0][N_DEV-1:0]    lane_req;
    logic [N_LVL-1:0][N_DEV-1:0]    lane_win;
    logic [N_LVL-1:0]               lane_any;
    logic [N_LVL:0]                 lvl_blk;
    logic [N_LVL:0][N_DEV-1:0]      acc;
    logic [N_DEV-1:0]               win_mask;
    logic [DW-1:0]                  win_idx;
    logic                           any_req;

    daisy_arb_lvlreg #(.N_DEV(N_DEV), .N_LVL(N_LVL)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_dev   (cfg_dev),
        .wr_lvl   (cfg_lvl),
        .held     (gnt),
        .lvl_flat (lvl_flat)
    );

    assign lvl_blk[0] = 1'b0;
    assign acc[0]     = '0;

    // one chain per level; a busy lower-numbered level masks every later one
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        for (genvar i = 0; i < N_DEV; i++) begin : g_dev
            assign lane_req[l][i] = req[i] && (lvl_flat[i*LW +: LW] == LW'(l));
        end

        daisy_arb_chain #(.N_DEV(N_DEV)) u_chain (
            .lane_req (lane_req[l]),
            .lane_win (lane_win[l]),
            .lane_any (lane_any[l])
        );

        assign lvl_blk[l + 1] = lvl_blk[l] | lane_any[l];
        assign acc[l + 1]     = acc[l] | (lvl_blk[l] ? '0 : lane_win[l]);
    end

    assign win_mask = acc[N_LVL];
    assign any_req  = lvl_blk[N_LVL];

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (win_mask[i]) win_idx = DW'(i);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            S_IDLE: begin
                if (any_req && !bus_busy) begin
                    state_d = S_GRANT;
                    owner_d = win_idx;
                end
            end
            S_GRANT: begin
                if (!req[owner_q]) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // outputs
    always_comb begin
        gnt = '0;
        if (state_q == S_GRANT) gnt[owner_q] = 1'b1;
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_pick_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_mask) && (any_req == (win_mask != '0)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & req) != '0) |=> (gnt == $past(gnt)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && ((gnt & req) == '0)) |=> (gnt == '0));

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && bus_busy) |=> (gnt == '0));

    p_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> ((gnt & ~$past(req)) == '0));
endmodule

// File: tb/daisy_arb_tb.sv
`timescale 1ns/1ps
module daisy_arb_tb;
    localparam int N  = 8;
    localparam int L  = 3;
    localparam int DW = 3;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          bus_busy = 1'b0;
    logic          cfg_we = 1'b0;
    logic [DW-1:0] cfg_dev = '0;
    logic [LW-1:0] cfg_lvl = '0;
    logic [N-1:0]  gnt;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    int m_owner = -1;
    int m_lvl[N];

    always #2.5 clk = ~clk;

    daisy_arb #(.N_DEV(N), .N_LVL(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
        .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_lvl(cfg_lvl), .gnt(gnt)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s gnt=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: best = smallest (level, index) among requesters
    always @(posedge clk) begin
        int nxt;
        int best_l;
        bit wok;
        if (!rst_n) begin
            m_owner = -1;
            foreach (m_lvl[i]) m_lvl[i] = L - 1;
        end else begin
            nxt = m_owner;
            wok = cfg_we && (int'(cfg_lvl) < L) && (int'(cfg_dev) != m_owner);
            if (m_owner >= 0) begin
                if (!req[m_owner]) nxt = -1;
            end else if (!bus_busy) begin
                best_l = L;
                for (int i = 0; i < N; i++) begin
                    if (req[i] && m_lvl[i] < best_l) begin
                        best_l = m_lvl[i];
                        nxt = i;
                    end
                end
            end
            if (wok) m_lvl[cfg_dev] = int'(cfg_lvl);
            m_owner = nxt;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [N-1:0] e;
        if (rst_n && !finished) begin
            e = (m_owner >= 0) ? (N'(1) << m_owner) : '0;
            chk(gnt == e, cur_tag, gnt, e);
            chk($countones(gnt) <= 1, "R2", gnt, e);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_gnt(input logic [N-1:0] exp, input string tag);
        chk(gnt == exp, tag, gnt, exp);
    endtask

    task automatic wr(input int dev, input int lvl);
        cfg_we = 1'b1; cfg_dev = DW'(dev); cfg_lvl = LW'(lvl);
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        expect_gnt('0, "R1");
        rst_n = 1'b1;

        // R3: all on default level, nearest requester first
        cur_tag = "R3";
        req = 8'hA8; step(); expect_gnt(8'h08, "R3");
        req[3] = 1'b0; step(); expect_gnt(8'h00, "R6");
        step(); expect_gnt(8'h20, "R3");
        req[5] = 1'b0; step(); expect_gnt(8'h00, "R6");
        step(); expect_gnt(8'h80, "R1");
        req = '0; step(); step();

        // R4: level overrides position; R5: no preemption
        cur_tag = "R4";
        wr(6, 0); wr(1, 1);
        req = 8'h43; step(); expect_gnt(8'h40, "R4");
        cur_tag = "R5";
        req[2] = 1'b1; wr(2, 0);
        step(); expect_gnt(8'h40, "R5");
        cur_tag = "R4";
        req[6] = 1'b0; step(); expect_gnt(8'h00, "R6");
        step(); expect_gnt(8'h04, "R4");
        req[2] = 1'b0; step(); step(); expect_gnt(8'h02, "R4");
        req[1] = 1'b0; step(); step(); expect_gnt(8'h01, "R3");

        // R9: write to holder ignored, write to waiting device accepted
        cur_tag = "R9";
        wr(0, 0); expect_gnt(8'h01, "R9");
        req = '0; step(); expect_gnt(8'h00, "R6");
        req = 8'h03; step(); expect_gnt(8'h02, "R9");
        wr(0, 0);
        req = '0; step();
        req = 8'h03; step(); expect_gnt(8'h01, "R9");
        req = '0; step(); step();

        // R10: out-of-range level dropped
        cur_tag = "R10";
        wr(7, 1); wr(7, 3);
        req = 8'hA0; step(); expect_gnt(8'h80, "R10");
        req = '0; step(); step();

        // R7 and R8
        cur_tag = "R7";
        bus_busy = 1'b1; req = 8'h08;
        step(); expect_gnt(8'h00, "R7");
        step(); expect_gnt(8'h00, "R7");
        bus_busy = 1'b0; step(); expect_gnt(8'h08, "R8");
        bus_busy = 1'b1; step(); expect_gnt(8'h08, "R7");
        bus_busy = 1'b0; req = '0; step(); expect_gnt(8'h00, "R8");
        step(); expect_gnt(8'h00, "R8");

        // random mix: writes collide with awards and releases
        cur_tag = "R9";
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (i == m_owner) req[i] = ($urandom % 4) != 0;
                else              req[i] = ($urandom % 3) == 0;
            end
            bus_busy = ($urandom % 5) == 0;
            cfg_we   = ($urandom % 4) == 0;
            cfg_dev  = DW'($urandom);
            cfg_lvl  = LW'($urandom);
            step();
        end
        cfg_we = 1'b0; req = '0; bus_busy = 1'b0;
        step(); step();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 gnt=%b expected=completion", gnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule